// File: doc/BRIEF.md
# DMA Hold Request Arbiter

This block hands the system bus between a minimum-logic 8-bit CPU and a DMA controller. It watches the CPU status and lock lines and follows the CPU bus-cycle phases (T1, T2, T3, wait states, T4), starting each cycle from the address-latch strobe. A hold request from the DMA controller is granted only at a safe point: while the CPU is passive and idle, or at the final T4 phase of a running cycle.

The CPU is frozen through its ready path, not through its own hold pins. On a grant the block disconnects the CPU side from the system bus and asserts a ready-disable line to the clock/ready generator. One clock later it connects the DMA side and raises hold acknowledge. When the request is withdrawn, the steps run in reverse order: acknowledge drops, the DMA side is disconnected, the CPU side is reconnected, and then ready is re-enabled together with a one-clock wait-circuit reset. A CPU cycle that stalled during the transfer then runs again from T1 on the system bus.

Top module: `dma_hold_arbiter`

## Requirements
- R1: A synchronous active-high reset leaves cpu_bus_en=1, dma_bus_en=0, hold_ack=0, ready_disable=0 and wait_reset=0.
- R2: While no CPU cycle is tracked, all status bits are 1 and cpu_lock_n is 1, a hold_req sampled high on an edge sets cpu_bus_en=0 and ready_disable=1 after that edge. After the next edge, dma_bus_en=1 and hold_ack=1.
- R3: While cpu_lock_n is 0 no grant occurs and the outputs keep their CPU-owns-bus values. The grant follows on the first edge after the lock is released.
- R4: An ale sampled high on an edge starts phase T1. T2 and T3 follow on the next edges. From T3 or a wait state the phase moves to T4 on an edge where rdy_in is 1 and ready_disable is 0, and stays in the wait state otherwise. T4 returns to idle. A pending request is granted no earlier than the edge on which the phase is T4, which is the ale edge plus 4 plus the number of wait states.
- R5: Once hold_ack is 1 it stays 1 on every edge on which hold_req is sampled high.
- R6: Release runs in order. On the edge where hold_req is first sampled low, hold_ack and dma_bus_en go to 0. On the next edge cpu_bus_en goes to 1. On the edge after that, ready_disable goes to 0 and wait_reset goes to 1 for exactly one clock.
- R7: cpu_bus_en and dma_bus_en are never both 1. Each handover includes one clock in which both are 0.
- R8: A cycle stalled in a wait state while ready_disable is 1 restarts at T1 on the edge where wait_reset is 1. It then needs T2, T3 and T4 before a new grant can occur.
- R9: ready_disable is 1 in every clock in which dma_bus_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all outputs are registered on it |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Hold request from the DMA controller |
| cpu_stat | input | STAT_W | CPU status lines, all ones when passive |
| cpu_lock_n | input | 1 | CPU lock line, low while locked |
| ale | input | 1 | Address-latch strobe marking the start of a CPU cycle |
| rdy_in | input | 1 | External ready from the memory and I/O side |
| hold_ack | output | 1 | Hold acknowledge to the DMA controller |
| cpu_bus_en | output | 1 | Connects the CPU address, data and command paths to the system bus |
| dma_bus_en | output | 1 | Connects the DMA side to the system bus |
| ready_disable | output | 1 | Forces not-ready at the clock/ready generator |
| wait_reset | output | 1 | One-clock reset pulse to the wait circuit |

## Verification
The risky coincidence is a hold request that is pending while a CPU cycle reaches T4, so that the grant decision and the end of the cycle fall on the same edge. The bench starts CPU cycles with a random number of wait states and raises the request at a random phase of each cycle. It predicts the exact grant edge and requires CPU-owns-bus outputs in every clock before it. The second coincidence is the wait-circuit reset landing on a cycle stalled in a wait state. The bench re-raises the request right after a release and judges the restart by the edge on which the next grant appears.

// File: rtl/dha_pkg.sv
package dha_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  typedef enum logic [2:0] {
    OWN_CPU     = 3'd0,
    OWN_GAP_DMA = 3'd1,
    OWN_DMA     = 3'd2,
    OWN_GAP_CPU = 3'd3,
    OWN_REARM   = 3'd4
  } owner_t;
endpackage

// File: rtl/dha_cycle_tracker.sv
module dha_cycle_tracker
  import dha_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ale,
  input  logic   rdy_in,
  input  logic   ready_block,
  input  logic   wait_rst,
  output phase_t phase
);
  logic ready_go;
  assign ready_go = rdy_in & ~ready_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
    end else if (ale) begin
      phase <= PH_T1;
    end else if (wait_rst && phase == PH_TW) begin
      phase <= PH_T1;          // stalled cycle restarts as if fresh
    end else begin
      unique case (phase)
        PH_T1:        phase <= PH_T2;
        PH_T2:        phase <= PH_T3;
        PH_T3, PH_TW: phase <= ready_go ? PH_T4 : PH_TW;
        PH_T4:        phase <= PH_IDLE;
        default:      phase <= PH_IDLE;
      endcase
    end
  end

  p_ale_starts_t1_r4: assert property (@(posedge clk) disable iff (rst)
    ale |=> phase == PH_T1);
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TW && ready_block && !ale && !wait_rst) |=> phase == PH_TW);
  p_restart_t1_r8: assert property (@(posedge clk) disable iff (rst)
    (wait_rst && phase == PH_TW && !ale) |=> phase == PH_T1);
endmodule

// File: rtl/dha_grant_window.sv
module dha_grant_window
  import dha_pkg::*;
#(
  parameter int STAT_W = 3
) (
  input  logic [STAT_W-1:0] cpu_stat,
  input  logic              cpu_lock_n,
  input  phase_t            phase,
  output logic              grant_ok
);
  logic passive;
  logic at_edge;

  assign passive  = (&cpu_stat) & cpu_lock_n;
  assign at_edge  = (phase == PH_IDLE) || (phase == PH_T4);
  assign grant_ok = passive & at_edge;
endmodule

// File: rtl/dha_handover_fsm.sv
module dha_handover_fsm
  import dha_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic grant_ok,
  output logic hold_ack,
  output logic cpu_bus_en,
  output logic dma_bus_en,
  output logic ready_disable,
  output logic wait_reset
);
  owner_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= OWN_CPU;
      hold_ack      <= 1'b0;
      cpu_bus_en    <= 1'b1;
      dma_bus_en    <= 1'b0;
      ready_disable <= 1'b0;
      wait_reset    <= 1'b0;
    end else begin
      wait_reset <= 1'b0;
      unique case (st)
        OWN_CPU: if (hold_req && grant_ok) begin
          cpu_bus_en    <= 1'b0;
          ready_disable <= 1'b1;
          st            <= OWN_GAP_DMA;
        end
        OWN_GAP_DMA: begin
          dma_bus_en <= 1'b1;
          hold_ack   <= 1'b1;
          st         <= OWN_DMA;
        end
        OWN_DMA: if (!hold_req) begin
          hold_ack   <= 1'b0;
          dma_bus_en <= 1'b0;
          st         <= OWN_GAP_CPU;
        end
        OWN_GAP_CPU: begin
          cpu_bus_en <= 1'b1;
          st         <= OWN_REARM;
        end
        OWN_REARM: begin
          ready_disable <= 1'b0;
          wait_reset    <= 1'b1;
          st            <= OWN_CPU;
        end
        default: st <= OWN_CPU;
      endcase
    end
  end

  p_grant_window_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_disable) |-> $past(grant_ok && hold_req));
  p_ack_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_req) |=> hold_ack);
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> !hold_ack);
  p_wait_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wait_reset |=> !wait_reset);
  p_rearm_order_r6: assert property (@(posedge clk) disable iff (rst)
    wait_reset |-> (cpu_bus_en && !ready_disable));
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(cpu_bus_en && dma_bus_en));
  p_gap_to_dma_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_bus_en) |-> $past(!cpu_bus_en));
  p_gap_to_cpu_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_bus_en) |-> $past(!dma_bus_en));
  p_dma_stalls_cpu_r9: assert property (@(posedge clk) disable iff (rst)
    dma_bus_en |-> ready_disable);
endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter
  import dha_pkg::*;
#(
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_req,
  input  logic [STAT_W-1:0] cpu_stat,
  input  logic              cpu_lock_n,
  input  logic              ale,
  input  logic              rdy_in,
  output logic              hold_ack,
  output logic              cpu_bus_en,
  output logic              dma_bus_en,
  output logic              ready_disable,
  output logic              wait_reset
);
  phase_t phase;
  logic   grant_ok;

  dha_cycle_tracker u_track (
    .clk         (clk),
    .rst         (rst),
    .ale         (ale),
    .rdy_in      (rdy_in),
    .ready_block (ready_disable),
    .wait_rst    (wait_reset),
    .phase       (phase)
  );

  dha_grant_window #(.STAT_W(STAT_W)) u_window (
    .cpu_stat   (cpu_stat),
    .cpu_lock_n (cpu_lock_n),
    .phase      (phase),
    .grant_ok   (grant_ok)
  );

  dha_handover_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .hold_req      (hold_req),
    .grant_ok      (grant_ok),
    .hold_ack      (hold_ack),
    .cpu_bus_en    (cpu_bus_en),
    .dma_bus_en    (dma_bus_en),
    .ready_disable (ready_disable),
    .wait_reset    (wait_reset)
  );
endmodule

// File: tb/tb_dma_hold_arbiter.sv
module tb_dma_hold_arbiter;
  localparam logic [4:0] V_CPU  = 5'b01000; // {ack,cpu_en,dma_en,rdy_dis,wait_rst}
  localparam logic [4:0] V_GAP  = 5'b00010;
  localparam logic [4:0] V_DMA  = 5'b10110;
  localparam logic [4:0] V_BACK = 5'b01010;
  localparam logic [4:0] V_WRST = 5'b01001;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_req = 1'b0;
  logic [2:0] cpu_stat = 3'b111;
  logic       cpu_lock_n = 1'b1;
  logic       ale = 1'b0;
  logic       rdy_in = 1'b1;
  logic       hold_ack, cpu_bus_en, dma_bus_en, ready_disable, wait_reset;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  typedef struct {
    int         at;
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];
  exp_t cur;
  logic [4:0] outv;

  dma_hold_arbiter dut (
    .clk(clk), .rst(rst), .hold_req(hold_req), .cpu_stat(cpu_stat),
    .cpu_lock_n(cpu_lock_n), .ale(ale), .rdy_in(rdy_in),
    .hold_ack(hold_ack), .cpu_bus_en(cpu_bus_en), .dma_bus_en(dma_bus_en),
    .ready_disable(ready_disable), .wait_reset(wait_reset)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the scoreboard and checks invariants every clock
  always @(negedge clk) begin
    #1;
    outv = {hold_ack, cpu_bus_en, dma_bus_en, ready_disable, wait_reset};
    if (!rst) begin
      n_chk++;
      if (cpu_bus_en && dma_bus_en) begin
        n_fail++;
        $display("FAIL R7 cycle %0d both enables high: actual %b expected no overlap", cyc, outv);
      end
      n_chk++;
      if (dma_bus_en && !ready_disable) begin
        n_fail++;
        $display("FAIL R9 cycle %0d ready not disabled during DMA: actual %b", cyc, outv);
      end
    end
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      cur = sb.pop_front();
      n_chk++;
      if (cur.at != cyc || outv !== cur.v) begin
        n_fail++;
        $display("FAIL %s cycle %0d actual %b expected %b (due %0d)", cur.tag, cyc, outv, cur.v, cur.at);
      end
    end
  end

  task automatic push(int at, logic [4:0] v, string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic expect_grant(int g, string tag);
    push(g, V_GAP, tag);
    push(g + 1, V_DMA, tag);
  endtask

  task automatic dma_hold(int n);
    for (int i = 1; i <= n; i++) push(cyc + i, V_DMA, "R5");
    repeat (n) @(negedge clk);
  endtask

  task automatic release_now();
    int d;
    d = cyc;
    hold_req = 1'b0;
    push(d + 1, V_GAP,  "R6");
    push(d + 2, V_BACK, "R6");
    push(d + 3, V_WRST, "R6");
    push(d + 4, V_CPU,  "R6");
  endtask

  // one CPU cycle with w wait states, request raised r clocks after T1 starts
  task automatic cpu_cycle_with_req(int w, int r);
    int k0, g;
    @(negedge clk);
    ale = 1'b1; cpu_stat = 3'b100; rdy_in = 1'b0;
    k0 = cyc + 1;
    g  = k0 + 4 + w;
    for (int c = k0; c < g; c++) push(c, V_CPU, "R4");
    expect_grant(g, "R4");
    while (cyc < g) begin
      @(negedge clk);
      ale = 1'b0;
      cpu_stat = (cyc >= k0 + 2) ? 3'b111 : 3'b100;
      rdy_in = (cyc >= k0 + 2 + w);
      if (cyc >= k0 + r) hold_req = 1'b1;
    end
    rdy_in = 1'b1;
    dma_hold(4);
    release_now();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int c, d, w, r;
    push(1, V_CPU, "R1");
    push(2, V_CPU, "R1");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2: grant from idle
    c = cyc;
    hold_req = 1'b1;
    expect_grant(c + 1, "R2");
    @(negedge clk);
    dma_hold(5);
    release_now();
    repeat (6) @(negedge clk);

    // R3: locked bus blocks the grant
    c = cyc;
    cpu_lock_n = 1'b0;
    hold_req = 1'b1;
    for (int i = 1; i <= 4; i++) push(c + i, V_CPU, "R3");
    repeat (4) @(negedge clk);
    cpu_lock_n = 1'b1;
    expect_grant(cyc + 1, "R3");
    @(negedge clk);
    dma_hold(3);
    release_now();
    repeat (6) @(negedge clk);

    // R4: requests arriving mid-cycle, random wait counts
    for (int k = 0; k < 8; k++) begin
      w = $urandom_range(0, 6);
      r = $urandom_range(0, 3 + w);
      cpu_cycle_with_req(w, r);
    end

    // R8: CPU cycle stalls during DMA and restarts from T1 after release
    c = cyc;
    hold_req = 1'b1;
    expect_grant(c + 1, "R8");
    @(negedge clk);
    for (int i = 1; i <= 11; i++) push(cyc + i, V_DMA, "R9");
    for (int i = 0; i < 11; i++) begin
      ale = (i == 0);
      cpu_stat = (i < 3) ? 3'b100 : 3'b111;
      rdy_in = 1'b1;
      @(negedge clk);
    end
    ale = 1'b0;
    d = cyc;
    release_now();
    push(d + 5, V_CPU, "R8");
    push(d + 6, V_CPU, "R8");
    push(d + 7, V_CPU, "R8");
    expect_grant(d + 8, "R8");
    @(negedge clk);
    hold_req = 1'b1;
    while (cyc < d + 8) @(negedge clk);
    dma_hold(2);
    release_now();
    repeat (8) @(negedge clk);

    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R6 scoreboard not drained: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule